// File: doc/BRIEF.md
# Power-Up Configuration Sequencer with Serial Chain Forwarding

This block walks a device through its start-up phases. After reset it holds the shared open-drain init line low while its configuration storage is cleared, then waits until nothing outside pulls that line low. In master mode it also waits a fixed delay before it starts to load. In slave mode it starts loading as soon as the line is released. Loading reads a serial bit stream. The stream is a start pattern, then a frame count, then that many parity-protected frames. A good last frame completes the configuration. A parity mismatch puts the block into a fault state, where it pulls the init line low again.

The block re-times every sampled serial bit onto the falling clock edge and drives it out, so that a second device chained downstream receives the same stream. A single clock serves as the configuration clock. The init line is sensed on `init_in`, and `init_drive_low` drives its open-drain pull-down. The board combines these two signals.

Top module: `cfgseq_top`

## Requirements
- R1: `cfg_pending_n` is 0 during reset and in every cycle until the configuration completes. It is 1 from the cycle after a successful load and stays 1 until the next reset.
- R2: `init_drive_low` is 1 while `rst` is high and for exactly CLEAR_CYCLES (default 16) clock cycles after `rst` is sampled low.
- R3: After the clearing phase, the block waits while `init_in` is 0. `din` has no effect during clearing or waiting.
- R4: In slave mode (`master_mode`=0), the first `din` bit that can be taken as stream data is the one sampled on the clock edge after the edge that sees `init_in`=1 in the wait state.
- R5: In master mode (`master_mode`=1), `init_in` must be seen high for MASTER_WAIT_CYCLES (default 3000, which is 30 µs at 100 MHz) consecutive edges before loading starts. A 0 on `init_in` during that delay sends the block back to waiting and restarts the delay.
- R6: While loading, bits are ignored until the last 8 sampled bits, oldest first, equal 8'b1011_0010.
- R7: The 8 bits that follow the start pattern are the frame count, most significant bit first. A count of 0 completes configuration right after the last count bit.
- R8: Each frame is 8 data bits followed by 1 parity bit, and the count of ones across all 9 bits must be even. Configuration completes after the parity bit of the last counted frame, provided that parity is correct.
- R9: A parity mismatch enters a fault state. In that state `init_drive_low` is 1 and `cfg_pending_n` is 0, and both stay so whatever `din` and `init_in` do, until reset.
- R10: `dout` changes only on the falling clock edge. It carries the `din` bit sampled on the rising edge 1.5 periods earlier, in every phase. `dout` is 1 during reset and for the first 1.5 periods after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock. Data is sampled on the rising edge. |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| master_mode | input | 1 | 1 = master (adds the timed delay), 0 = slave |
| init_in | input | 1 | Sensed level of the shared open-drain init line |
| din | input | 1 | Serial configuration data |
| init_drive_low | output | 1 | 1 = pull the init line low |
| cfg_pending_n | output | 1 | Low until configuration has completed |
| dout | output | 1 | Forwarded serial data for a downstream device |

## Verification
The assertions rely on `init_in` settling before each rising edge. They also rely on `init_in` never reading high while the block itself drives the line, because the line is wired-AND with `init_drive_low`. The bench meets both conditions. It derives `init_in` from the block's own pull-down ANDed with a modelled external holder. It changes `din`, `master_mode` and the holder only after the falling edge. `master_mode` is held constant between resets, because the assertions and the model read it only in the wait phases.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    typedef enum logic [2:0] {
        ST_CLEAR,
        ST_HOLD,
        ST_MDELAY,
        ST_LOAD,
        ST_DONE,
        ST_FAIL
    } cfg_state_e;

    typedef enum logic [1:0] {
        PH_HUNT,
        PH_COUNT,
        PH_FRAME
    } rx_phase_e;

    typedef struct packed {
        logic load_ok;
        logic load_err;
    } rx_result_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cfgseq_timer.sv
module cfgseq_timer #(
    parameter int unsigned LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = cfgseq_pkg::cnt_width(LEN);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LAST);
endmodule

// File: rtl/cfgseq_rx.sv
module cfgseq_rx
    import cfgseq_pkg::*;
#(
    parameter int unsigned PRE_W   = 8,
    parameter logic [PRE_W-1:0] PREAMBLE = 8'hB2,
    parameter int unsigned LEN_W   = 8,
    parameter int unsigned FRAME_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic       din,
    output rx_result_t res
);
    localparam int unsigned SPAN = (LEN_W > FRAME_W + 1) ? LEN_W : FRAME_W + 1;
    localparam int unsigned BCW  = cnt_width(SPAN + 1);
    localparam logic [BCW-1:0] LEN_LAST = BCW'(LEN_W - 1);
    localparam logic [BCW-1:0] PAR_POS  = BCW'(FRAME_W);

    rx_phase_e        phase;
    logic [PRE_W-1:0] win;
    logic [LEN_W-1:0] len_sr;
    logic [LEN_W-1:0] frames_left;
    logic [BCW-1:0]   bcnt;
    logic             par;

    logic [PRE_W-1:0] win_next;
    logic [LEN_W-1:0] len_next;
    logic             count_end;
    logic             parity_bit;
    logic             parity_bad;

    assign win_next   = {win[PRE_W-2:0], din};
    assign len_next   = {len_sr[LEN_W-2:0], din};
    assign count_end  = (phase == PH_COUNT) && (bcnt == LEN_LAST);
    assign parity_bit = (phase == PH_FRAME) && (bcnt == PAR_POS);
    assign parity_bad = par ^ din;

    always_comb begin
        res.load_err = active && parity_bit && parity_bad;
        res.load_ok  = active && ((count_end && (len_next == '0)) ||
                                  (parity_bit && !parity_bad &&
                                   (frames_left == LEN_W'(1))));
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            phase       <= PH_HUNT;
            win         <= '1;
            len_sr      <= '0;
            frames_left <= '0;
            bcnt        <= '0;
            par         <= 1'b0;
        end else begin
            unique case (phase)
                PH_HUNT: begin
                    win <= win_next;
                    if (win_next == PREAMBLE) begin
                        phase <= PH_COUNT;
                        bcnt  <= '0;
                    end
                end
                PH_COUNT: begin
                    len_sr <= len_next;
                    if (count_end) begin
                        phase       <= PH_FRAME;
                        frames_left <= len_next;
                        bcnt        <= '0;
                        par         <= 1'b0;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
                PH_FRAME: begin
                    if (parity_bit) begin
                        frames_left <= frames_left - 1'b1;
                        bcnt        <= '0;
                        par         <= 1'b0;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                        par  <= par ^ din;
                    end
                end
                default: phase <= PH_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/cfgseq_fwd.sv
module cfgseq_fwd (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic stage_a;
    logic stage_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_a <= 1'b1;
            stage_b <= 1'b1;
        end else begin
            stage_a <= din;
            stage_b <= stage_a;
        end
    end

    always_ff @(negedge clk) begin
        if (rst)
            dout <= 1'b1;
        else
            dout <= stage_b;
    end
endmodule

// File: rtl/cfgseq_top.sv
module cfgseq_top
    import cfgseq_pkg::*;
#(
    parameter int unsigned CLEAR_CYCLES       = 16,
    parameter int unsigned MASTER_WAIT_CYCLES = 3000,
    parameter int unsigned PRE_W              = 8,
    parameter logic [PRE_W-1:0] PREAMBLE      = 8'hB2,
    parameter int unsigned LEN_W              = 8,
    parameter int unsigned FRAME_W            = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic master_mode,
    input  logic init_in,
    input  logic din,
    output logic init_drive_low,
    output logic cfg_pending_n,
    output logic dout
);
    cfg_state_e state;
    cfg_state_e state_nxt;
    rx_result_t rx_res;
    logic       clear_exp;
    logic       delay_exp;

    cfgseq_timer #(.LEN(CLEAR_CYCLES)) u_clear_tmr (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_CLEAR),
        .expired (clear_exp)
    );

    cfgseq_timer #(.LEN(MASTER_WAIT_CYCLES)) u_delay_tmr (
        .clk     (clk),
        .rst     (rst),
        .run     ((state == ST_MDELAY) && init_in),
        .expired (delay_exp)
    );

    cfgseq_rx #(
        .PRE_W    (PRE_W),
        .PREAMBLE (PREAMBLE),
        .LEN_W    (LEN_W),
        .FRAME_W  (FRAME_W)
    ) u_rx (
        .clk    (clk),
        .rst    (rst),
        .active (state == ST_LOAD),
        .din    (din),
        .res    (rx_res)
    );

    cfgseq_fwd u_fwd (
        .clk  (clk),
        .rst  (rst),
        .din  (din),
        .dout (dout)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_CLEAR:  if (clear_exp) state_nxt = ST_HOLD;
            ST_HOLD:   if (init_in) state_nxt = master_mode ? ST_MDELAY : ST_LOAD;
            ST_MDELAY: begin
                if (!init_in)      state_nxt = ST_HOLD;
                else if (delay_exp) state_nxt = ST_LOAD;
            end
            ST_LOAD: begin
                if (rx_res.load_err)     state_nxt = ST_FAIL;
                else if (rx_res.load_ok) state_nxt = ST_DONE;
            end
            default: state_nxt = state;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_CLEAR;
        else
            state <= state_nxt;
    end

    assign init_drive_low = (state == ST_CLEAR) || (state == ST_FAIL);
    assign cfg_pending_n  = (state == ST_DONE);
endmodule

// File: rtl/cfgseq_chk.sv
module cfgseq_chk
    import cfgseq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       init_in,
    input logic       din,
    input logic       init_drive_low,
    input logic       cfg_pending_n,
    input logic       dout,
    input cfg_state_e state
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)
            age <= '0;
        else if (age != 2'd3)
            age <= age + 1'b1;
    end

    a_r1_done_sticky: assert property (@(posedge clk) disable iff (rst)
        cfg_pending_n |=> cfg_pending_n);

    a_r1_no_drive_when_done: assert property (@(posedge clk) disable iff (rst)
        !(init_drive_low && cfg_pending_n));

    a_r3_hold_while_low: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) && !init_in |=> (state == ST_HOLD));

    a_r9_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FAIL) |=> (state == ST_FAIL) && init_drive_low && !cfg_pending_n);

    a_r10_forward_latency: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (dout == $past(din, 2)));
endmodule

bind cfgseq_top cfgseq_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .init_in        (init_in),
    .din            (din),
    .init_drive_low (init_drive_low),
    .cfg_pending_n  (cfg_pending_n),
    .dout           (dout),
    .state          (state)
);

// File: tb/cfgseq_top_tb.sv
module cfgseq_top_tb;
    localparam int CLR  = 16;
    localparam int MW   = 3000;
    localparam int PRE  = 8'hB2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic master_mode = 1'b0;
    logic din = 1'b1;
    logic ext_hold = 1'b1;
    logic init_in;
    logic init_drive_low;
    logic cfg_pending_n;
    logic dout;

    int vectors = 0;
    int errors  = 0;
    string tag = "R1";

    // model state: 0 clear, 1 hold, 2 master delay, 3 load, 4 done, 5 fail
    int ms, ccnt, tcnt, pph, win, nbits, lenv, frames, ones;
    int fq[$];

    always #5 clk = ~clk;

    assign init_in = ~(init_drive_low | ext_hold);

    cfgseq_top u_dut (
        .clk            (clk),
        .rst            (rst),
        .master_mode    (master_mode),
        .init_in        (init_in),
        .din            (din),
        .init_drive_low (init_drive_low),
        .cfg_pending_n  (cfg_pending_n),
        .dout           (dout)
    );

    function automatic bit m_drive();
        return (ms == 0) || (ms == 5);
    endfunction

    task automatic model_edge();
        bit line;
        line = !(m_drive() || ext_hold);
        if (rst) begin
            ms = 0; ccnt = 0; tcnt = 0;
            fq = '{1, 1};
            return;
        end
        fq.push_back(din);
        if (fq.size() > 2) void'(fq.pop_front());
        case (ms)
            0: if (ccnt == CLR - 1) ms = 1; else ccnt++;
            1: if (line) begin
                   if (master_mode) begin ms = 2; tcnt = 0; end
                   else begin ms = 3; pph = 0; win = 255; end
               end
            2: if (!line) ms = 1;
               else if (tcnt == MW - 1) begin ms = 3; pph = 0; win = 255; end
               else tcnt++;
            3: case (pph)
                   0: begin
                       win = ((win << 1) | din) & 255;
                       if (win == PRE) begin pph = 1; nbits = 0; lenv = 0; end
                   end
                   1: begin
                       lenv = lenv * 2 + din; nbits++;
                       if (nbits == 8) begin
                           if (lenv == 0) ms = 4;
                           else begin pph = 2; frames = lenv; nbits = 0; ones = 0; end
                       end
                   end
                   default: begin
                       ones += din; nbits++;
                       if (nbits == 9) begin
                           if (ones % 2 != 0) ms = 5;
                           else begin
                               frames--;
                               if (frames == 0) ms = 4;
                               else begin nbits = 0; ones = 0; end
                           end
                       end
                   end
               endcase
            default: ;
        endcase
    endtask

    task automatic check_bit(input string what, input logic got, input logic exp);
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s at %0t: actual %b expected %b", tag, what, $time, got, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        #8;
        vectors++;
        check_bit("cfg_pending_n (R1)", cfg_pending_n, ms == 4);
        check_bit("init_drive_low (R2/R9)", init_drive_low, m_drive());
        check_bit("dout (R10)", dout, fq[0][0]);
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic do_reset(input logic mm);
        rst = 1'b1; master_mode = mm; ext_hold = 1'b1; din = 1'b1;
        cycles(3);
        rst = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        din = b;
        cycle();
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_frame(input logic [7:0] v, input logic good);
        send_byte(v);
        send_bit(good ? ^v : ~^v);
    endtask

    task automatic noise(input int n);
        for (int i = 0; i < n; i++) begin
            din = ((i * 7 + 3) % 5) < 2;
            cycle();
        end
    endtask

    initial begin
        // R1 R2 reset state and clearing window
        tag = "R2";
        do_reset(1'b0);
        // R3 held off externally, stream noise and a start pattern ignored
        tag = "R3";
        noise(30);
        send_byte(8'hB2);
        send_byte(8'h00);
        noise(10);
        // R4 slave release, R6 junk before start pattern
        tag = "R4";
        ext_hold = 1'b0; din = 1'b1;
        cycles(4);
        tag = "R6";
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        send_byte(8'hB2);
        // R8 two good frames
        tag = "R8";
        send_byte(8'd2);
        send_frame(8'h3C, 1'b1);
        send_frame(8'h81, 1'b1);
        din = 1'b1;
        // R1 stays done, ignores later stream
        tag = "R1";
        noise(20);
        ext_hold = 1'b1;
        cycles(5);

        // R7 zero frame count
        tag = "R7";
        do_reset(1'b0);
        ext_hold = 1'b0;
        cycles(CLR + 2);
        send_byte(8'hB2);
        send_byte(8'h00);
        din = 1'b0;
        cycles(10);

        // R9 parity error, sticky fault
        tag = "R9";
        do_reset(1'b0);
        ext_hold = 1'b0;
        cycles(CLR + 2);
        send_byte(8'hB2);
        send_byte(8'd3);
        send_frame(8'hA7, 1'b1);
        send_frame(8'h10, 1'b0);
        send_byte(8'hB2);
        send_byte(8'h00);
        noise(40);
        ext_hold = 1'b1;
        cycles(5);
        ext_hold = 1'b0;
        cycles(5);

        // R5 master delay, restarted by an external low
        tag = "R5";
        do_reset(1'b1);
        cycles(CLR + 3);
        ext_hold = 1'b0;
        cycles(MW / 2);
        ext_hold = 1'b1;
        send_byte(8'hB2);
        ext_hold = 1'b0;
        din = 1'b1;
        cycles(MW - 2);
        send_byte(8'hB2);
        send_byte(8'd1);
        send_frame(8'hFF, 1'b1);
        din = 1'b1;
        cycles(10);

        // R8 frame ending early ignored parity mistakes only at parity bit
        tag = "R8";
        do_reset(1'b0);
        ext_hold = 1'b0;
        cycles(CLR + 1);
        send_byte(8'hB2);
        send_byte(8'd4);
        send_frame(8'h00, 1'b1);
        send_frame(8'hFE, 1'b1);
        send_frame(8'h55, 1'b1);
        send_frame(8'h01, 1'b1);
        cycles(6);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule